// File: doc/BRIEF.md
# Shift and Rotate Unit with Double Step

This block performs the shift, rotate and byte-swap class of operations of a small 16-bit processor core. It holds four working registers. Each operation reads one of them, shifts, rotates or swaps it by one or two positions, writes the result back into the same register, and produces new sign, zero, carry and overflow flags together with the cycle cost of the operation. The caller supplies the current carry and overflow flags. In the double-step form the overflow flag acts as a second carry bit: it is shifted in behind the carry, and it captures the second bit shifted out.

A strobe starts each operation. The register array is written on the clock edge that samples the strobe, and the flag, result and cycle outputs are registered on that same edge. A separate load port places data into a register, and a peek port reads any register back, so the caller can set up operands and observe results. For one cycle after each operation the block raises a marker that tells the core not to take an interrupt at that boundary.

Top module: `shift_rot_unit`

## Requirements
- R1: `sel_i` picks the target register R0..R3. On the edge that samples it, `exec_i` writes the result back into that register, and `load_i` writes `load_data_i` into it. When both are high in the same cycle, `exec_i` has priority. `peek_data_o` shows register `peek_sel_i` at all times.
- R2: When `dbl_i`=0 the operation moves by one step and `cycles_o` is 6. When `dbl_i`=1 it moves by two steps and `cycles_o` is 8. All outputs are updated on the edge that samples `exec_i`.
- R3: Rotate left through carry (op 2). Single step: the old carry enters bit 0 and old bit 15 becomes the carry. Double step: the old carry lands in bit 1, the old overflow in bit 0, old bit 15 becomes the carry and old bit 14 becomes the overflow. A single step never changes the overflow flag.
- R4: Rotate right through carry (op 6). Single step: the old carry enters bit 15 and old bit 0 becomes the carry. Double step: the result is {old overflow, old carry, old bits 15..2}, with carry from old bit 0 and overflow from old bit 1.
- R5: Arithmetic right shift (op 5) and arithmetic right shift into carry (op 7) copy the original bit 15 into each vacated position. Op 7 also sets the carry from old bit 0 and, in the double step, the overflow from old bit 1.
- R6: Left shift into carry (op 3) shifts zeros in and sets the carry from old bit 15. In the double step it also sets the overflow from old bit 14.
- R7: Byte swap (op 0). The single form exchanges the high and low bytes. The double form copies the low byte into both byte positions.
- R8: The sign output is result bit 7 for ops 0, 4, 5, 6 and 7, and result bit 15 for ops 1, 2 and 3. The zero output is set exactly when the 16-bit result is zero.
- R9: An operation that does not define the carry or overflow flag passes the incoming `carry_i` / `ovf_i` value through unchanged. Ops 0, 1, 4 and 5 define neither flag, and single steps never define the overflow flag.
- R10: `intr_block_o` is high for exactly the one cycle after each sampled `exec_i`, and low otherwise.
- R11: Plain logical shifts shift zeros in: op 1 shifts left and op 4 shifts right, by one or two positions.
- R12: After reset all four registers and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Write `load_data_i` into register `sel_i` |
| load_data_i | input | 16 | Data for the load port |
| exec_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation: 0 swap, 1 shl, 2 rol-c, 3 shl-c, 4 shr, 5 sar, 6 ror-c, 7 sar-c |
| dbl_i | input | 1 | 1 = double step |
| sel_i | input | 2 | Target register |
| carry_i | input | 1 | Current carry flag |
| ovf_i | input | 1 | Current overflow flag |
| peek_sel_i | input | 2 | Register to show on `peek_data_o` |
| peek_data_o | output | 16 | Contents of register `peek_sel_i` |
| result_o | output | 16 | Result of the last operation |
| sign_o | output | 1 | New sign flag |
| zero_o | output | 1 | New zero flag |
| carry_o | output | 1 | New carry flag |
| ovf_o | output | 1 | New overflow flag |
| cycles_o | output | 4 | Cycle cost of the last operation |
| intr_block_o | output | 1 | Interrupt must not be taken at this boundary |

## Verification
Every result of an operation (the register write-back, the result, the four flags, the cycle count and the interrupt marker) becomes visible one clock edge after the cycle in which `exec_i` is driven high. The bench drives inputs on the falling edge and checks those outputs, and the register through the combinational peek port, on the next falling edge. One cycle later, with the strobe low, it checks that the interrupt marker has dropped. Loads are checked through the peek port one cycle after they are driven, in the same way.

// File: rtl/sru_pkg.sv
package sru_pkg;

    localparam int SRU_DATA_W = 16;
    localparam int SRU_NREGS  = 4;

    typedef enum logic [2:0] {
        OP_SWAP = 3'd0,
        OP_SHL  = 3'd1,
        OP_ROLC = 3'd2,
        OP_SHLC = 3'd3,
        OP_SHR  = 3'd4,
        OP_SAR  = 3'd5,
        OP_RORC = 3'd6,
        OP_SARC = 3'd7
    } sru_op_e;

    // ops whose sign flag comes from the low byte
    function automatic logic sign_from_low(input sru_op_e op);
        return (op == OP_SWAP) || (op == OP_SHR) || (op == OP_SAR) ||
               (op == OP_RORC) || (op == OP_SARC);
    endfunction

endpackage

// File: rtl/sru_shifter.sv
module sru_shifter
    import sru_pkg::*;
#(
    parameter int DATA_W = SRU_DATA_W
) (
    input  sru_op_e           op,
    input  logic              dbl,
    input  logic [DATA_W-1:0] val,
    input  logic              cin,
    input  logic              oin,
    output logic [DATA_W-1:0] res,
    output logic              sgn,
    output logic              zro,
    output logic              cout,
    output logic              oout
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] sar_1, sar_2;

    assign sar_1 = {val[DATA_W-1], val[DATA_W-1:1]};
    assign sar_2 = {val[DATA_W-1], val[DATA_W-1], val[DATA_W-1:2]};

    always_comb begin
        res  = val;
        cout = cin;
        oout = oin;
        unique case (op)
            OP_SWAP: res = dbl ? {val[HALF-1:0], val[HALF-1:0]}
                               : {val[HALF-1:0], val[DATA_W-1:HALF]};
            OP_SHL:  res = dbl ? (val << 2) : (val << 1);
            OP_ROLC: begin
                res  = dbl ? {val[DATA_W-3:0], cin, oin} : {val[DATA_W-2:0], cin};
                cout = val[DATA_W-1];
                if (dbl) oout = val[DATA_W-2];
            end
            OP_SHLC: begin
                res  = dbl ? (val << 2) : (val << 1);
                cout = val[DATA_W-1];
                if (dbl) oout = val[DATA_W-2];
            end
            OP_SHR:  res = dbl ? (val >> 2) : (val >> 1);
            OP_SAR:  res = dbl ? sar_2 : sar_1;
            OP_RORC: begin
                res  = dbl ? {oin, cin, val[DATA_W-1:2]} : {cin, val[DATA_W-1:1]};
                cout = val[0];
                if (dbl) oout = val[1];
            end
            OP_SARC: begin
                res  = dbl ? sar_2 : sar_1;
                cout = val[0];
                if (dbl) oout = val[1];
            end
            default: res = val;
        endcase
        sgn = sign_from_low(op) ? res[HALF-1] : res[DATA_W-1];
        zro = (res == '0);
    end

endmodule

// File: rtl/sru_regfile.sv
module sru_regfile #(
    parameter int NREGS  = 4,
    parameter int DATA_W = 16,
    localparam int SEL_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [SEL_W-1:0]  rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data
);
    logic [DATA_W-1:0] mem_d [NREGS];
    logic [DATA_W-1:0] mem_q [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_entry
        always_comb begin
            mem_d[g] = mem_q[g];
            if (wr_en && (wr_addr == SEL_W'(g))) mem_d[g] = wr_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= '0;
            else        mem_q[g] <= mem_d[g];
        end
    end

    assign rd_a_data = mem_q[rd_a_addr];
    assign rd_b_data = mem_q[rd_b_addr];

    // R1: a write lands in the addressed register on the next edge
    assert_writeback_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
    import sru_pkg::*;
#(
    parameter int DATA_W = SRU_DATA_W,
    parameter int NREGS  = SRU_NREGS,
    parameter int CYC_W  = 4,
    parameter int CYC_SINGLE = 6,
    parameter int CYC_DOUBLE = 8,
    localparam int SEL_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              exec_i,
    input  logic [2:0]        op_i,
    input  logic              dbl_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              carry_i,
    input  logic              ovf_i,
    input  logic [SEL_W-1:0]  peek_sel_i,
    output logic [DATA_W-1:0] peek_data_o,
    output logic [DATA_W-1:0] result_o,
    output logic              sign_o,
    output logic              zero_o,
    output logic              carry_o,
    output logic              ovf_o,
    output logic [CYC_W-1:0]  cycles_o,
    output logic              intr_block_o
);
    localparam logic [CYC_W-1:0] CYC_S = CYC_W'(CYC_SINGLE);
    localparam logic [CYC_W-1:0] CYC_D = CYC_W'(CYC_DOUBLE);

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              s;
        logic              z;
        logic              c;
        logic              o;
        logic [CYC_W-1:0]  cyc;
        logic              blk;
    } out_state_t;

    out_state_t st_d, st_q;

    sru_op_e           op;
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] sh_res;
    logic              sh_s, sh_z, sh_c, sh_o;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;

    assign op = sru_op_e'(op_i);

    sru_shifter #(.DATA_W(DATA_W)) shifter_i (
        .op   (op),
        .dbl  (dbl_i),
        .val  (operand),
        .cin  (carry_i),
        .oin  (ovf_i),
        .res  (sh_res),
        .sgn  (sh_s),
        .zro  (sh_z),
        .cout (sh_c),
        .oout (sh_o)
    );

    assign wr_en   = exec_i | load_i;
    assign wr_data = exec_i ? sh_res : load_data_i;

    sru_regfile #(.NREGS(NREGS), .DATA_W(DATA_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (sel_i),
        .wr_data   (wr_data),
        .rd_a_addr (sel_i),
        .rd_a_data (operand),
        .rd_b_addr (peek_sel_i),
        .rd_b_data (peek_data_o)
    );

    always_comb begin
        st_d     = st_q;
        st_d.blk = 1'b0;
        if (exec_i) begin
            st_d.res = sh_res;
            st_d.s   = sh_s;
            st_d.z   = sh_z;
            st_d.c   = sh_c;
            st_d.o   = sh_o;
            st_d.cyc = dbl_i ? CYC_D : CYC_S;
            st_d.blk = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o     = st_q.res;
    assign sign_o       = st_q.s;
    assign zero_o       = st_q.z;
    assign carry_o      = st_q.c;
    assign ovf_o        = st_q.o;
    assign cycles_o     = st_q.cyc;
    assign intr_block_o = st_q.blk;

    // R2: cycle cost follows the step count
    assert_cycle_cost_R2: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i |=> (cycles_o == ($past(dbl_i) ? CYC_D : CYC_S)));

    // R3: a single step never alters the overflow flag
    assert_single_keeps_ovf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && !dbl_i) |=> (ovf_o == $past(ovf_i)));

    // R8: zero flag agrees with the registered result
    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        intr_block_o |-> (zero_o == (result_o == '0)));

    // R9: ops that define no flags pass carry and overflow through
    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && (op_i == 3'd0 || op_i == 3'd1 || op_i == 3'd4 || op_i == 3'd5))
        |=> (carry_o == $past(carry_i) && ovf_o == $past(ovf_i)));

    // R10: marker follows the strobe by exactly one cycle
    assert_intr_marker_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exec_i |=> intr_block_o);
    assert_intr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> !intr_block_o);

    // R1: the written register reads back the reported result
    assert_peek_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && peek_sel_i == sel_i) |=>
        (($past(peek_sel_i) != peek_sel_i) || (peek_data_o == result_o)));

endmodule

// File: tb/shift_rot_unit_tb.sv
`timescale 1ns/1ps
module shift_rot_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [15:0] load_data_i = '0;
    logic        exec_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic        dbl_i = 1'b0;
    logic [1:0]  sel_i = '0;
    logic        carry_i = 1'b0;
    logic        ovf_i = 1'b0;
    logic [1:0]  peek_sel_i = '0;
    logic [15:0] peek_data_o, result_o;
    logic        sign_o, zero_o, carry_o, ovf_o, intr_block_o;
    logic [3:0]  cycles_o;

    int n_vec = 0;
    int n_bad = 0;
    logic [15:0] shadow [4];
    bit done = 1'b0;

    always #4 clk = ~clk;

    shift_rot_unit dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_data_i(load_data_i),
        .exec_i(exec_i), .op_i(op_i), .dbl_i(dbl_i), .sel_i(sel_i),
        .carry_i(carry_i), .ovf_i(ovf_i), .peek_sel_i(peek_sel_i),
        .peek_data_o(peek_data_o), .result_o(result_o), .sign_o(sign_o),
        .zero_o(zero_o), .carry_o(carry_o), .ovf_o(ovf_o),
        .cycles_o(cycles_o), .intr_block_o(intr_block_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // returns {result[15:0], sign, zero, carry, ovf}
    function automatic logic [19:0] model(input int op, input bit d,
                                          input logic [15:0] v, input bit c, input bit o);
        logic [15:0] r;
        bit nc = c, no = o, low_sign;
        int steps = d ? 2 : 1;
        r = v;
        low_sign = (op == 0 || op >= 4);
        if (op == 0) r = d ? {v[7:0], v[7:0]} : {v[7:0], v[15:8]};
        else begin
            for (int k = 0; k < steps; k++) begin
                case (op)
                    1, 3: r = {r[14:0], 1'b0};
                    2:    r = {r[14:0], (k == 0) ? c : o};
                    4:    r = {1'b0, r[15:1]};
                    5, 7: r = {v[15], r[15:1]};
                    6:    r = {(k == 0) ? c : o, r[15:1]};
                    default: r = r;
                endcase
            end
            if (op == 2 || op == 3) begin nc = v[15]; if (d) no = v[14]; end
            if (op == 6 || op == 7) begin nc = v[0];  if (d) no = v[1];  end
        end
        return {r, low_sign ? r[7] : r[15], (r == 16'h0), nc, no};
    endfunction

    function automatic string op_tag(input int op);
        case (op)
            0: return "R7";
            2: return "R3";
            3: return "R6";
            5, 7: return "R5";
            6: return "R4";
            default: return "R11";
        endcase
    endfunction

    task automatic do_load(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk);
        load_i = 1'b1; sel_i = s; load_data_i = v;
        @(negedge clk);
        load_i = 1'b0; peek_sel_i = s;
        #1;
        shadow[s] = v;
        chk("R1 load", peek_data_o, v);
    endtask

    task automatic do_exec(input int op, input bit d, input logic [1:0] s,
                           input bit c, input bit o, input bit with_load);
        logic [19:0] e;
        bit flag_def_c, flag_def_o;
        e = model(op, d, shadow[s], c, o);
        flag_def_c = (op == 2 || op == 3 || op == 6 || op == 7);
        flag_def_o = flag_def_c && d;
        @(negedge clk);
        exec_i = 1'b1; op_i = 3'(op); dbl_i = d; sel_i = s; carry_i = c; ovf_i = o;
        load_i = with_load; load_data_i = 16'hA5A5;
        @(negedge clk);
        exec_i = 1'b0; load_i = 1'b0; peek_sel_i = s;
        #1;
        shadow[s] = e[19:4];
        chk(op_tag(op), result_o, e[19:4]);
        chk("R8 sign", sign_o, e[3]);
        chk("R8 zero", zero_o, e[2]);
        chk(flag_def_c ? op_tag(op) : "R9 carry", carry_o, e[1]);
        chk(flag_def_o ? op_tag(op) : "R9 ovf", ovf_o, e[0]);
        chk("R2 cycles", cycles_o, d ? 8 : 6);
        chk("R10 marker high", intr_block_o, 1'b1);
        chk(with_load ? "R1 exec priority" : "R1 writeback", peek_data_o, e[19:4]);
        @(negedge clk);
        #1;
        chk("R10 marker low", intr_block_o, 1'b0);
    endtask

    initial begin : watchdog
        #1500000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int unused_seed;
        unused_seed = $urandom(32'h5EED1234);
        for (int i = 0; i < 4; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        // R12: reset state
        chk("R12 result", result_o, 0);
        chk("R12 flags", {sign_o, zero_o, carry_o, ovf_o}, 0);
        chk("R12 cycles", cycles_o, 0);
        chk("R12 marker", intr_block_o, 0);
        for (int i = 0; i < 4; i++) begin
            peek_sel_i = 2'(i);
            #1;
            chk("R12 regs", peek_data_o, 0);
        end
        rst_n = 1'b1;

        // directed corner cases
        do_load(2'd0, 16'hC000); do_exec(2, 1, 2'd0, 1, 0, 0); // R3 double: 0x0002, C=1, O=1
        do_load(2'd1, 16'h0003); do_exec(6, 1, 2'd1, 0, 1, 0); // R4 double: 0x8000, sign from bit 7
        do_load(2'd2, 16'h1280); do_exec(0, 1, 2'd2, 0, 0, 0); // R7 double swap: 0x8080
        do_load(2'd2, 16'h1234); do_exec(0, 0, 2'd2, 1, 1, 0); // R7 single swap
        do_load(2'd3, 16'h8000); do_exec(5, 1, 2'd3, 0, 0, 0); // R5 replicate: 0xE000
        do_load(2'd3, 16'h8000); do_exec(1, 0, 2'd3, 1, 0, 0); // R11 to zero
        do_load(2'd0, 16'h4001); do_exec(3, 1, 2'd0, 0, 0, 0); // R6 overflow from bit 14
        do_load(2'd1, 16'h8003); do_exec(7, 1, 2'd1, 0, 0, 0); // R5 carry variant
        do_load(2'd2, 16'h0101); do_exec(4, 1, 2'd2, 1, 1, 0); // R11 right
        do_load(2'd3, 16'hFFFF); do_exec(2, 0, 2'd3, 0, 1, 0); // R3 single keeps overflow
        do_exec(1, 1, 2'd3, 0, 0, 1);                          // R1 exec beats load

        // constrained random
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 8) == 0) do_load(2'($urandom % 4), 16'($urandom));
            do_exec(int'($urandom % 8), bit'($urandom % 2), 2'($urandom % 4),
                    bit'($urandom % 2), bit'($urandom % 2), 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule